// File: doc/BRIEF.md
# Temperature Alert Output Controller

This block drives the shared, active-low alert line of a two-channel temperature monitor. A conversion engine hands it one reading at a time, and each reading carries a channel number and a valid strobe. The block compares each reading with that channel's upper and lower limits. It also watches a level fault flag for each sensing diode. From these it keeps three read-only status vectors: over-limit, under-limit and fault. A host clears these vectors by writing ones to the clear inputs. The output is a pull-down enable, so several such outputs can share one wired-OR line with a pull-up resistor.

A configuration bit selects one of two modes. In latched (interrupt) mode the alert follows the pending status bits. It stays on until the host clears those bits, and a global mask bit can silence it. In hysteretic (comparator) mode the alert sets when an unmasked channel goes over its upper limit. It releases only once every unmasked channel has read below its upper limit minus a shared hysteresis value. While it is held, the over-limit status bits cannot be cleared, and they clear themselves at release. A mask bit for each channel keeps that channel from raising the alert in both modes.

Top module: `temp_alert_ctrl`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), all status bits are 0 and `alert_drv` is 0. The comparator latch is released.
- R2: Readings, limits and hysteresis are 8-bit values. Readings and limits are two's complement; hysteresis is unsigned. On a strobe, the named channel's over-limit bit sets when the reading is strictly greater than its upper limit. Its under-limit bit sets when the reading is strictly less than its lower limit. Both bits are visible after that edge. A reading equal to a limit sets nothing.
- R3: While `diode_fault[c]` is high at a clock edge, `stat_flt[c]` is set after that edge.
- R4: `cfg_comp`=0 selects latched mode. There, writing 1 to `clr_hi`, `clr_lo` or `clr_flt` clears the matching status bit. If a set condition holds in the same cycle, the set wins, and the condition persists until an in-range reading arrives for that channel. The alert stays asserted until the host clears the bits.
- R5: In latched mode, `mask_all`=1 holds `alert_drv` at 0 while the status bits keep updating. When `mask_all` returns to 0, the alert follows the pending bits again.
- R6: `cfg_comp`=1 selects comparator mode. There, `alert_drv` rises after the edge that takes an unmasked channel's reading strictly above its upper limit.
- R7: In comparator mode the alert releases only after every unmasked channel's latest reading is strictly below its release threshold (upper limit minus hysteresis). A reading equal to the threshold holds the alert.
- R8: In comparator mode, an over-limit status bit ignores host clears while the alert is held. All over-limit bits clear at the edge where the alert releases.
- R9: In comparator mode, `mask_all` has no effect on `alert_drv`.
- R10: A channel with `chan_mask[c]`=1 cannot assert the alert in either mode, yet its status bits still update.
- R11: The release threshold saturates at -128 when upper limit minus hysteresis would be smaller. A reading of -128 then never releases the alert.
- R12: A strobe changes the state of only the channel named by `smp_chan`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Reading strobe |
| smp_chan | input | 1 | Channel number of the reading |
| smp_temp | input | 8 | Reading, two's complement |
| hi_lim | input | 16 | Upper limits, channel c at bits [8c+7:8c] |
| lo_lim | input | 16 | Lower limits, same packing |
| hyst | input | 8 | Shared hysteresis, unsigned |
| diode_fault | input | 2 | Level fault flag for each channel |
| cfg_comp | input | 1 | 0 latched mode, 1 comparator mode |
| mask_all | input | 1 | Global alert mask (latched mode only) |
| chan_mask | input | 2 | Mask bits for each channel |
| clr_hi | input | 2 | Write-one-to-clear for over-limit bits |
| clr_lo | input | 2 | Write-one-to-clear for under-limit bits |
| clr_flt | input | 2 | Write-one-to-clear for fault bits |
| stat_hi | output | 2 | Over-limit status |
| stat_lo | output | 2 | Under-limit status |
| stat_flt | output | 2 | Fault status |
| alert_drv | output | 1 | 1 = pull the shared alert line low |

## Verification
In latched mode every 8-bit reading is swept against fixed limits, so each reading lands above, between, equal to or below the limits. This separates strict from non-strict comparison and shows that the unstrobed channel stays untouched. In comparator mode, readings between 0 and 60 follow a trip at 80 for several hysteresis values. Each reading either holds or releases the alert, which shows where the release threshold sits and that it holds on equality. Directed sequences cover the remaining cases: set-versus-clear collisions, a trip on one channel followed by a cool-down on the other, each mask, and thresholds that saturate.

// File: rtl/tac_pkg.sv
package tac_pkg;
  localparam int TEMP_W = 8;
  localparam int EXT_W  = TEMP_W + 2;

  // Release threshold: upper limit minus hysteresis, floored at the most negative value.
  function automatic logic signed [TEMP_W-1:0] rel_level(
    input logic signed [TEMP_W-1:0] hi,
    input logic        [TEMP_W-1:0] hy);
    logic signed [EXT_W-1:0] diff;
    logic signed [EXT_W-1:0] floor_v;
    floor_v = -(EXT_W'(1) <<< (TEMP_W-1));
    diff = {{2{hi[TEMP_W-1]}}, hi} - {2'b00, hy};
    if (diff < floor_v) rel_level = floor_v[TEMP_W-1:0];
    else                rel_level = diff[TEMP_W-1:0];
  endfunction

  function automatic logic is_over(input logic signed [TEMP_W-1:0] t,
                                   input logic signed [TEMP_W-1:0] lim);
    is_over = (t > lim);
  endfunction

  function automatic logic is_under(input logic signed [TEMP_W-1:0] t,
                                    input logic signed [TEMP_W-1:0] lim);
    is_under = (t < lim);
  endfunction
endpackage

// File: rtl/tac_chan_eval.sv
module tac_chan_eval
  import tac_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     hit,
  input  logic signed [TEMP_W-1:0] temp,
  input  logic signed [TEMP_W-1:0] hi_lim,
  input  logic signed [TEMP_W-1:0] lo_lim,
  input  logic        [TEMP_W-1:0] hyst,
  output logic                     over_d,
  output logic                     under_d,
  output logic                     cool_d
);
  logic over_q, under_q, cool_q;
  logic signed [TEMP_W-1:0] rel_thr;

  assign rel_thr = rel_level(hi_lim, hyst);

  always_comb begin
    over_d  = hit ? is_over(temp, hi_lim)   : over_q;
    under_d = hit ? is_under(temp, lo_lim)  : under_q;
    cool_d  = hit ? is_under(temp, rel_thr) : cool_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      over_q  <= 1'b0;
      under_q <= 1'b0;
      cool_q  <= 1'b1;
    end else begin
      over_q  <= over_d;
      under_q <= under_d;
      cool_q  <= cool_d;
    end
  end
endmodule

// File: rtl/tac_status.sv
module tac_status #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           comp_mode,
  input  logic           cmp_act_q,
  input  logic           release_ev,
  input  logic [NCH-1:0] over_d,
  input  logic [NCH-1:0] under_d,
  input  logic [NCH-1:0] fault,
  input  logic [NCH-1:0] clr_hi,
  input  logic [NCH-1:0] clr_lo,
  input  logic [NCH-1:0] clr_flt,
  output logic [NCH-1:0] stat_hi,
  output logic [NCH-1:0] stat_lo,
  output logic [NCH-1:0] stat_flt
);
  logic           hi_locked;
  logic [NCH-1:0] hi_keep;

  assign hi_locked = comp_mode && cmp_act_q;

  always_comb begin
    if (comp_mode && release_ev) hi_keep = '0;
    else if (hi_locked)          hi_keep = stat_hi;
    else                         hi_keep = stat_hi & ~clr_hi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_hi  <= '0;
      stat_lo  <= '0;
      stat_flt <= '0;
    end else begin
      stat_hi  <= hi_keep | over_d;
      stat_lo  <= (stat_lo & ~clr_lo) | under_d;
      stat_flt <= (stat_flt & ~clr_flt) | fault;
    end
  end
endmodule

// File: rtl/tac_alert_core.sv
module tac_alert_core #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           comp_mode,
  input  logic           mask_all,
  input  logic [NCH-1:0] chan_mask,
  input  logic [NCH-1:0] over_d,
  input  logic [NCH-1:0] cool_d,
  input  logic [NCH-1:0] pend,
  output logic           cmp_act_q,
  output logic           release_ev,
  output logic           alert_drv
);
  logic cmp_act_d;
  logic any_trip, all_cool, int_alert;

  assign any_trip  = |(over_d & ~chan_mask);
  assign all_cool  = &(cool_d | chan_mask);
  assign cmp_act_d = cmp_act_q ? !all_cool : any_trip;
  assign release_ev = cmp_act_q && !cmp_act_d;
  assign int_alert = !mask_all && (|(pend & ~chan_mask));
  assign alert_drv = comp_mode ? cmp_act_q : int_alert;

  always_ff @(posedge clk) begin
    if (rst) cmp_act_q <= 1'b0;
    else     cmp_act_q <= cmp_act_d;
  end
endmodule

// File: rtl/temp_alert_ctrl.sv
module temp_alert_ctrl
  import tac_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  smp_valid,
  input  logic [CW-1:0]         smp_chan,
  input  logic [TEMP_W-1:0]     smp_temp,
  input  logic [NCH*TEMP_W-1:0] hi_lim,
  input  logic [NCH*TEMP_W-1:0] lo_lim,
  input  logic [TEMP_W-1:0]     hyst,
  input  logic [NCH-1:0]        diode_fault,
  input  logic                  cfg_comp,
  input  logic                  mask_all,
  input  logic [NCH-1:0]        chan_mask,
  input  logic [NCH-1:0]        clr_hi,
  input  logic [NCH-1:0]        clr_lo,
  input  logic [NCH-1:0]        clr_flt,
  output logic [NCH-1:0]        stat_hi,
  output logic [NCH-1:0]        stat_lo,
  output logic [NCH-1:0]        stat_flt,
  output logic                  alert_drv
);
  logic [NCH-1:0] over_d, under_d, cool_d, hit;
  logic           cmp_act, release_ev;
  logic [NCH-1:0] pend;

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      assign hit[c] = smp_valid && (smp_chan == CW'(c));
      tac_chan_eval u_eval (
        .clk    (clk),
        .rst    (rst),
        .hit    (hit[c]),
        .temp   (smp_temp),
        .hi_lim (hi_lim[c*TEMP_W +: TEMP_W]),
        .lo_lim (lo_lim[c*TEMP_W +: TEMP_W]),
        .hyst   (hyst),
        .over_d (over_d[c]),
        .under_d(under_d[c]),
        .cool_d (cool_d[c])
      );
    end
  endgenerate

  assign pend = stat_hi | stat_lo | stat_flt;

  tac_alert_core #(.NCH(NCH)) u_core (
    .clk       (clk),
    .rst       (rst),
    .comp_mode (cfg_comp),
    .mask_all  (mask_all),
    .chan_mask (chan_mask),
    .over_d    (over_d),
    .cool_d    (cool_d),
    .pend      (pend),
    .cmp_act_q (cmp_act),
    .release_ev(release_ev),
    .alert_drv (alert_drv)
  );

  tac_status #(.NCH(NCH)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .comp_mode (cfg_comp),
    .cmp_act_q (cmp_act),
    .release_ev(release_ev),
    .over_d    (over_d),
    .under_d   (under_d),
    .fault     (diode_fault),
    .clr_hi    (clr_hi),
    .clr_lo    (clr_lo),
    .clr_flt   (clr_flt),
    .stat_hi   (stat_hi),
    .stat_lo   (stat_lo),
    .stat_flt  (stat_flt)
  );
endmodule

// File: rtl/tac_checker.sv
module tac_checker #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           cfg_comp,
  input logic           mask_all,
  input logic [NCH-1:0] chan_mask,
  input logic [NCH-1:0] diode_fault,
  input logic [NCH-1:0] clr_hi,
  input logic [NCH-1:0] stat_hi,
  input logic [NCH-1:0] stat_flt,
  input logic           alert_drv
);
  // R5: global mask silences the latched-mode alert
  p_mask_all_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (!cfg_comp && mask_all) |-> !alert_drv);

  // R8: release clears every over-limit bit when no channel is masked
  p_comp_autoclear_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_comp && alert_drv && chan_mask == '0) |=>
      (alert_drv || !cfg_comp || stat_hi == '0));

  // R10: with every channel masked the comparator latch never sets
  p_comp_allmask_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_comp && (&chan_mask) && !alert_drv) |=> (!alert_drv || !cfg_comp));

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_chk
      // R3: a fault level is captured at the next edge
      p_fault_sets_r3: assert property (@(posedge clk) disable iff (rst)
        diode_fault[c] |=> stat_flt[c]);
      // R4: a latched-mode bit survives when no clear is written
      p_int_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (!cfg_comp && stat_hi[c] && !clr_hi[c]) |=> stat_hi[c]);
      // R8: a held comparator alert keeps the over-limit bit set
      p_comp_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_comp && alert_drv && stat_hi[c]) |=>
          (stat_hi[c] || !alert_drv || !cfg_comp));
    end
  endgenerate
endmodule

bind temp_alert_ctrl tac_checker #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_comp   (cfg_comp),
  .mask_all   (mask_all),
  .chan_mask  (chan_mask),
  .diode_fault(diode_fault),
  .clr_hi     (clr_hi),
  .stat_hi    (stat_hi),
  .stat_flt   (stat_flt),
  .alert_drv  (alert_drv)
);

// File: tb/sim_temp_alert_ctrl.sv
module sim_temp_alert_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic [0:0] smp_chan = '0;
  logic [7:0] smp_temp = '0;
  logic [15:0] hi_lim = '0, lo_lim = '0;
  logic [7:0] hyst = '0;
  logic [1:0] diode_fault = '0, chan_mask = '0;
  logic cfg_comp = 1'b0, mask_all = 1'b0;
  logic [1:0] clr_hi = '0, clr_lo = '0, clr_flt = '0;
  logic [1:0] stat_hi, stat_lo, stat_flt;
  logic alert_drv;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  temp_alert_ctrl #(.NCH(NCH)) u0 (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_temp(smp_temp), .hi_lim(hi_lim), .lo_lim(lo_lim), .hyst(hyst),
    .diode_fault(diode_fault), .cfg_comp(cfg_comp), .mask_all(mask_all),
    .chan_mask(chan_mask), .clr_hi(clr_hi), .clr_lo(clr_lo), .clr_flt(clr_flt),
    .stat_hi(stat_hi), .stat_lo(stat_lo), .stat_flt(stat_flt), .alert_drv(alert_drv)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rel_of(input int hi, input int hy);
    int r = hi - hy;
    return (r < -128) ? -128 : r;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic strobe(input int ch, input int t);
    @(negedge clk);
    smp_valid = 1'b1; smp_chan = ch[0:0]; smp_temp = t[7:0];
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk); clr_hi = '1; clr_lo = '1; clr_flt = '1;
    @(negedge clk); clr_hi = '0; clr_lo = '0; clr_flt = '0;
  endtask

  task automatic set_lims(input int h0, input int l0, input int h1, input int l1);
    hi_lim = {h1[7:0], h0[7:0]};
    lo_lim = {l1[7:0], l0[7:0]};
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    int rel;
    bit exp_a;
    set_lims(40, -20, 40, -20);
    do_reset();
    @(negedge clk);
    // R1
    chk(alert_drv == 0 && stat_hi == 0 && stat_lo == 0 && stat_flt == 0, "R1 reset",
        {alert_drv, stat_hi, stat_lo, stat_flt}, 0);

    // R2 / R12: full sweep of ch0 against hi=40, lo=-20
    for (int t = -128; t < 128; t++) begin
      strobe(0, t);
      chk(stat_hi[0] == (t > 40) && stat_lo[0] == (t < -20), "R2 compare",
          {stat_hi[0], stat_lo[0]}, {(t > 40), (t < -20)});
      chk(alert_drv == ((t > 40) || (t < -20)), "R2 alert", alert_drv, (t > 40) || (t < -20));
      chk(stat_hi[1] == 0 && stat_lo[1] == 0, "R12 other channel", {stat_hi[1], stat_lo[1]}, 0);
      strobe(0, 0);
      clear_all();
    end

    // R4: set wins over clear while the condition persists
    strobe(0, 60);
    @(negedge clk); clr_hi = 2'b01;
    @(negedge clk); clr_hi = 2'b00;
    chk(stat_hi[0] == 1, "R4 set wins", stat_hi[0], 1);
    strobe(0, 10);
    chk(alert_drv == 1, "R4 alert held after in-range", alert_drv, 1);
    clear_all();
    chk(alert_drv == 0 && stat_hi == 0, "R4 cleared", {alert_drv, stat_hi}, 0);

    // R3: fault level
    @(negedge clk); diode_fault = 2'b10;
    @(negedge clk); diode_fault = 2'b00;
    chk(stat_flt == 2'b10 && alert_drv == 1, "R3 fault", {stat_flt, alert_drv}, 5);
    clear_all();
    chk(stat_flt == 0 && alert_drv == 0, "R3 fault cleared", {stat_flt, alert_drv}, 0);

    // R5: global mask in latched mode
    @(negedge clk); mask_all = 1'b1;
    strobe(1, 70);
    chk(alert_drv == 0, "R5 masked", alert_drv, 0);
    chk(stat_hi == 2'b10, "R5 status updates", stat_hi, 2);
    @(negedge clk); mask_all = 1'b0;
    @(negedge clk);
    chk(alert_drv == 1, "R5 unmasked", alert_drv, 1);
    strobe(1, 0); clear_all();

    // R10: channel mask in latched mode
    @(negedge clk); chan_mask = 2'b01;
    strobe(0, 90);
    chk(alert_drv == 0 && stat_hi[0] == 1, "R10 latched chan mask", {alert_drv, stat_hi[0]}, 1);
    strobe(0, 0); clear_all();
    @(negedge clk); chan_mask = 2'b00;

    // R6 / R7 / R8: comparator sweep
    cfg_comp = 1'b1;
    set_lims(50, -100, 50, -100);
    for (int k = 0; k < 3; k++) begin
      hyst = (k == 0) ? 8'd0 : (k == 1) ? 8'd7 : 8'd30;
      rel = rel_of(50, hyst);
      for (int t = 0; t <= 60; t++) begin
        do_reset();
        strobe(0, 80);
        chk(alert_drv == 1, "R6 trip", alert_drv, 1);
        strobe(0, t);
        exp_a = !(t < rel);
        chk(alert_drv == exp_a, "R7 release point", alert_drv, exp_a);
        chk(stat_hi[0] == exp_a, "R8 auto clear", stat_hi[0], exp_a);
      end
    end

    // R8: clear ignored while held; R9: global mask ignored
    hyst = 8'd5;
    do_reset();
    strobe(0, 80);
    @(negedge clk); clr_hi = 2'b01; mask_all = 1'b1;
    @(negedge clk); clr_hi = 2'b00;
    chk(stat_hi[0] == 1, "R8 clear blocked", stat_hi[0], 1);
    strobe(0, 48);
    chk(stat_hi[0] == 1, "R8 clear blocked after cooling", stat_hi[0], 1);
    chk(alert_drv == 1, "R9 mask_all ignored", alert_drv, 1);
    @(negedge clk); mask_all = 1'b0;

    // R7: every channel must cool
    do_reset();
    strobe(0, 80); strobe(1, 80);
    strobe(0, -50);
    chk(alert_drv == 1, "R7 other channel hot", alert_drv, 1);
    strobe(1, -50);
    chk(alert_drv == 0 && stat_hi == 0, "R7 all cool", {alert_drv, stat_hi}, 0);

    // R10: channel mask in comparator mode
    do_reset();
    @(negedge clk); chan_mask = 2'b10;
    strobe(1, 90);
    chk(alert_drv == 0, "R10 comparator chan mask", alert_drv, 0);
    chk(stat_hi[1] == 1, "R10 masked status updates", stat_hi[1], 1);
    @(negedge clk); chan_mask = 2'b00;

    // R11: saturated release threshold
    set_lims(-120, -128, 50, -100);
    hyst = 8'd50;
    do_reset();
    strobe(0, -100);
    strobe(0, -128);
    chk(alert_drv == 1, "R11 saturated hold", alert_drv, 1);
    hyst = 8'd7;
    do_reset();
    strobe(0, -100);
    strobe(0, -128);
    chk(alert_drv == 0, "R11 unsaturated release", alert_drv, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule